// File: doc/BRIEF.md
# Mailbox-Style Peripheral Clock Gate

This block produces one clock-enable strobe per peripheral from a single master clock. Each peripheral has its own enable and its own division factor, chosen from divide-by-1, 2, 4 or 8. All strobes are cut from one free-running phase counter, so peripherals that share a divider tick in the same cycle.

Software reaches the per-peripheral state through one 32-bit command word that works like a mailbox. A write command names a peripheral and carries the new enable and division code for it. A read command names only a peripheral. It changes no state, and it loads that peripheral's current settings into a readback word. The readback word keeps that value until the next read command.

Top module: `pclk_gate_mbox`

## Requirements
- R1: With division code k (0 to 3, meaning divide by 1, 2, 4 or 8), an enabled peripheral's strobe is high in exactly those cycles where the number of clock edges since reset release is a multiple of 2^k. All peripherals share this phase.
- R2: A command with bit 12 = 1 stores bit 28 as the enable and bits [17:16] as the division code for the peripheral whose ID is in bits [5:0]. The strobe follows the new setting from the cycle after the command edge.
- R3: A command with bit 12 = 0 is a read request. It changes no enable and no divider. From the next cycle, the readback shows that peripheral's ID in [5:0], its divider in [17:16] and its enable in [28], with every other bit 0, including bit 12.
- R4: The fields of the command word are decoded at fixed positions: ID [5:0], command bit 12, division code [17:16], enable bit 28. All other bits are ignored.
- R5: After reset every peripheral is disabled with division code 0, no strobe is high, and the readback word is 0.
- R6: A write that clears a peripheral's enable forces its strobe low in the very next cycle, whatever the divider phase.
- R7: A write whose ID is at or above N_PERIPH changes nothing. A read of such an ID returns that ID with enable 0 and division code 0.
- R8: The readback word changes only on a read command. Write commands and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command word valid this cycle |
| cmd_data | input | 32 | Command word (ID, command bit, division code, enable) |
| cmd_rdata | output | 32 | Readback word of the last read request |
| clk_en | output | N_PERIPH | One clock-enable strobe per peripheral |

## Verification
A command is captured on the edge at which it is presented. The stored settings, and therefore the strobe vector, follow from the cycle right after that edge. The readback word is updated on the same edge. The bench drives each command half a cycle before its edge and compares both outputs at the next falling edge. It compares the whole strobe vector in every cycle against a model that counts clock edges since reset release. This catches a strobe that is late, early or out of phase by one cycle.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
    localparam int ID_W    = 6;
    localparam int CMD_BIT = 12;
    localparam int DIV_LSB = 16;
    localparam int DIV_W   = 2;
    localparam int EN_BIT  = 28;
    localparam int WORD_W  = 32;

    typedef struct packed {
        logic             is_wr;
        logic [ID_W-1:0]  id;
        logic [DIV_W-1:0] div;
        logic             en;
    } cmd_t;

    typedef struct packed {
        logic [ID_W-1:0]  id;
        logic [DIV_W-1:0] div;
        logic             en;
    } rb_t;

    function automatic cmd_t decode_cmd(input logic [WORD_W-1:0] w);
        cmd_t c;
        c.is_wr = w[CMD_BIT];
        c.id    = w[ID_W-1:0];
        c.div   = w[DIV_LSB +: DIV_W];
        c.en    = w[EN_BIT];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] encode_rb(input rb_t r);
        logic [WORD_W-1:0] w;
        w = '0;
        w[ID_W-1:0]          = r.id;
        w[DIV_LSB +: DIV_W]  = r.div;
        w[EN_BIT]            = r.en;
        return w;
    endfunction
endpackage

// File: rtl/pcg_phase_ctr.sv
module pcg_phase_ctr #(
    parameter int N_CODES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [N_CODES-1:0] tick
);
    localparam int CNT_W = (N_CODES > 1) ? N_CODES - 1 : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // tick[k] marks cycles whose phase is a multiple of 2^k
    assign tick[0] = 1'b1;
    for (genvar k = 1; k < N_CODES; k++) begin : g_tick
        assign tick[k] = (cnt_q[k-1:0] == '0);
    end

    p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/pcg_cfg_bank.sv
module pcg_cfg_bank #(
    parameter int N_PERIPH = 64,
    parameter int ID_W     = 6,
    parameter int DIV_W    = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_stb,
    input  logic [ID_W-1:0]                wr_id,
    input  logic                           wr_en,
    input  logic [DIV_W-1:0]               wr_div,
    output logic [N_PERIPH-1:0]            en_o,
    output logic [N_PERIPH-1:0][DIV_W-1:0] div_o
);
    typedef struct packed {
        logic [N_PERIPH-1:0]            en;
        logic [N_PERIPH-1:0][DIV_W-1:0] div;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_stb) begin
            for (int i = 0; i < N_PERIPH; i++) begin
                if ({1'b0, wr_id} == (ID_W+1)'(i)) begin
                    bank_d.en[i]  = wr_en;
                    bank_d.div[i] = wr_div;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign en_o  = bank_q.en;
    assign div_o = bank_q.div;

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(bank_q));
endmodule

// File: rtl/pcg_strobe_gen.sv
module pcg_strobe_gen #(
    parameter int N_PERIPH = 64,
    parameter int DIV_W    = 2
) (
    input  logic [N_PERIPH-1:0]            en,
    input  logic [N_PERIPH-1:0][DIV_W-1:0] div,
    input  logic [(1<<DIV_W)-1:0]          tick,
    output logic [N_PERIPH-1:0]            strobe
);
    for (genvar i = 0; i < N_PERIPH; i++) begin : g_ch
        assign strobe[i] = en[i] & tick[div[i]];
    end
endmodule

// File: rtl/pclk_gate_mbox.sv
module pclk_gate_mbox
    import pcg_pkg::*;
#(
    parameter int N_PERIPH = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_wr,
    input  logic [31:0]         cmd_data,
    output logic [31:0]         cmd_rdata,
    output logic [N_PERIPH-1:0] clk_en
);
    localparam int N_CODES = 1 << DIV_W;
    localparam int IDX_W   = (N_PERIPH > 1) ? $clog2(N_PERIPH) : 1;

    cmd_t                           cmd;
    logic                           in_range;
    logic                           do_wr, do_rd;
    logic [IDX_W-1:0]               idx;
    logic [N_PERIPH-1:0]            en_vec;
    logic [N_PERIPH-1:0][DIV_W-1:0] div_vec;
    logic [N_CODES-1:0]             tick;
    rb_t                            rb_d, rb_q;

    assign cmd      = decode_cmd(cmd_data);
    assign in_range = {1'b0, cmd.id} < (ID_W+1)'(N_PERIPH);
    assign do_wr    = cmd_wr & cmd.is_wr & in_range;
    assign do_rd    = cmd_wr & ~cmd.is_wr;
    assign idx      = cmd.id[IDX_W-1:0];

    pcg_phase_ctr #(.N_CODES(N_CODES)) i_ctr (
        .clk (clk),
        .rst_n (rst_n),
        .tick (tick)
    );

    pcg_cfg_bank #(.N_PERIPH(N_PERIPH), .ID_W(ID_W), .DIV_W(DIV_W)) i_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (do_wr),
        .wr_id  (cmd.id),
        .wr_en  (cmd.en),
        .wr_div (cmd.div),
        .en_o   (en_vec),
        .div_o  (div_vec)
    );

    pcg_strobe_gen #(.N_PERIPH(N_PERIPH), .DIV_W(DIV_W)) i_gen (
        .en     (en_vec),
        .div    (div_vec),
        .tick   (tick),
        .strobe (clk_en)
    );

    always_comb begin
        rb_d = rb_q;
        if (do_rd) begin
            rb_d.id  = cmd.id;
            rb_d.div = '0;
            rb_d.en  = 1'b0;
            for (int i = 0; i < N_PERIPH; i++) begin
                if ({1'b0, cmd.id} == (ID_W+1)'(i)) begin
                    rb_d.div = div_vec[i];
                    rb_d.en  = en_vec[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rb_q <= '0;
        else        rb_q <= rb_d;
    end

    assign cmd_rdata = encode_rb(rb_q);

    p_wr_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        do_wr |=> en_vec[$past(idx)] == $past(cmd.en)
               && div_vec[$past(idx)] == $past(cmd.div));
    p_rd_nostore_r3: assert property (@(posedge clk) disable iff (!rst_n)
        do_rd |=> $stable(en_vec) && $stable(div_vec));
    p_stop_now_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (do_wr && !cmd.en) |=> !clk_en[$past(idx)]);
    p_oor_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !in_range) |=> $stable(en_vec) && $stable(div_vec));
    p_oor_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rd && !in_range) |=> !cmd_rdata[EN_BIT] && cmd_rdata[DIV_LSB +: DIV_W] == '0);
    p_rb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !do_rd |=> $stable(cmd_rdata));
endmodule

// File: tb/test_pclk_gate_mbox.sv
module test_pclk_gate_mbox;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_wr = 1'b0;
    logic [31:0]   cmd_data = '0;
    logic [31:0]   cmd_rdata;
    logic [NP-1:0] clk_en;

    int n_tests = 0;
    int n_fail  = 0;
    int edges   = 0;
    bit m_en [NP];
    int m_div [NP];
    logic [31:0] m_rb = '0;

    pclk_gate_mbox #(.N_PERIPH(NP)) i_pclk_gate_mbox (
        .clk (clk), .rst_n (rst_n), .cmd_wr (cmd_wr),
        .cmd_data (cmd_data), .cmd_rdata (cmd_rdata), .clk_en (clk_en)
    );

    always #5 clk = ~clk;

    always @(posedge clk) if (rst_n) edges <= edges + 1;

    function automatic logic [NP-1:0] exp_vec();
        logic [NP-1:0] v;
        for (int i = 0; i < NP; i++)
            v[i] = m_en[i] && ((edges % (1 << m_div[i])) == 0);
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic chk_vec(input string req);
        chk(req, 32'(clk_en), 32'(exp_vec()));
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic do_cmd(input logic [31:0] w);
        int id;
        cmd_wr = 1'b1;
        cmd_data = w;
        id = int'(w[5:0]);
        @(negedge clk);
        cmd_wr = 1'b0;
        cmd_data = '0;
        if (w[12]) begin
            if (id < NP) begin
                m_en[id] = w[28];
                m_div[id] = int'(w[17:16]);
            end
        end else begin
            m_rb = 32'(id);
            if (id < NP) m_rb = m_rb | (32'(m_en[id]) << 28) | (32'(m_div[id]) << 16);
        end
    endtask

    function automatic logic [31:0] wr_word(input int id, input int dv, input bit en);
        return (32'(en) << 28) | (32'(dv) << 16) | 32'h1000 | 32'(id);
    endfunction

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NP; i++) begin m_en[i] = 0; m_div[i] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R5: reset state
        chk("R5 strobes", 32'(clk_en), 32'h0);
        chk("R5 readback", cmd_rdata, 32'h0);
        for (int p = 0; p < NP; p++) begin
            do_cmd(32'(p));
            chk("R5 read after reset", cmd_rdata, 32'(p));
        end
        // R1 R2 R4: sweep every peripheral and divider code
        for (int p = 0; p < NP; p++) begin
            for (int k = 0; k < 4; k++) begin
                do_cmd(wr_word(p, k, 1'b1));
                for (int c = 0; c < 16; c++) begin
                    chk_vec("R1/R2 strobe pattern");
                    @(negedge clk);
                end
            end
            // leave mixed dividers behind
            do_cmd(wr_word(p, p % 4, 1'b1));
        end
        // R3: reads reflect state, stores nothing; stray bits ignored (R4)
        for (int p = 0; p < NP; p++) begin
            do_cmd(32'h2003_0000 | 32'(p));
            chk("R3 readback", cmd_rdata, m_rb);
            chk_vec("R3 read stores nothing");
            chk("R4 cmd bit reads 0", 32'(cmd_rdata[12]), 32'h0);
        end
        // R8: write after read leaves readback alone
        do_cmd(32'h5);
        chk("R3 readback p5", cmd_rdata, m_rb);
        do_cmd(wr_word(5, 3, 1'b0));
        chk("R8 write keeps readback", cmd_rdata, m_rb);
        repeat (3) @(negedge clk);
        chk("R8 idle keeps readback", cmd_rdata, m_rb);
        // R6: disable stops strobe at every phase
        for (int ph = 0; ph < 8; ph++) begin
            do_cmd(wr_word(1, 0, 1'b1));
            repeat (ph) @(negedge clk);
            do_cmd(wr_word(1, 0, 1'b0));
            chk("R6 immediate stop", 32'(clk_en[1]), 32'h0);
            chk_vec("R6 vector");
        end
        // R7: out-of-range IDs
        for (int id = NP; id < 64; id++) begin
            do_cmd(wr_word(id, 3, 1'b1));
            chk_vec("R7 write ignored");
            do_cmd(32'(id));
            chk("R7 oor read", cmd_rdata, 32'(id));
        end
        for (int p = 0; p < NP; p++) begin
            do_cmd(32'(p));
            chk("R7 state untouched", cmd_rdata, m_rb);
        end
        // R1: long run with mixed dividers
        for (int c = 0; c < 40; c++) begin
            chk_vec("R1 long run");
            @(negedge clk);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule